// File: doc/BRIEF.md
# Zero-Rotated CIC Decimator

This block decimates a two's-complement sample stream by a factor R that is set at run time. It is built like a cascaded integrator-comb decimator with N integrators running at the input rate and N combs running at the decimated rate. One comb has a longer delay than the others: 2R−r input samples instead of R. This moves the first zero of that stage closer to the edge of the first aliasing band, which raises the worst-case alias rejection while leaving the passband droop almost unchanged.

The longer comb is built without a delay line. One capture register takes the integrator output r accepted samples after each downsampling instant. That value is exactly R−r samples older than the value the next downsampling instant will take. A second register, enabled at the low rate, adds one more decimated period of delay. Each decimated result is presented for one cycle with a valid strobe. Samples are accepted only when `in_valid` is high, so the stream may have gaps.

Top module: `zr_cic_decim`

## Requirements
- R1: A synchronous active-low reset clears `out_valid` and `out_data` to 0 and empties every integrator, comb, capture and delay register, so the first result after reset is exactly 0.
- R2: The first sample accepted after reset is a downsampling instant, and every R-th accepted sample after it is one too (accepted indices 0, R, 2R, …). `out_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted that sample, and is low at all other times.
- R3: The result for downsampling instant m equals Σ h[k]·x[mR−1−k]. Here x is the accepted sample sequence (zero before index 0) and h is the convolution of N−1 all-ones boxcars of length R with one all-ones boxcar of length 2R−r.
- R4: A constant input c gives, once settled, the result c·R^(N−1)·(2R−r).
- R5: A cycle with `in_valid` low advances no state: `out_valid` stays low and `out_data` keeps its value.
- R6: R is taken from `dec_factor` and r from `rot_shift`, with 2 ≤ R ≤ 2^RW−1 and 0 < r < R. Both are held constant between resets.
- R7: `out_data` is W+N·RW+1 bits wide, in two's complement. A sustained full-scale negative input gives the exact negative product with no overflow.
- R8: The capture strobe never coincides with a downsampling instant. It falls exactly r accepted samples after each one, which gives the modified comb its 2R−r delay (visible in the impulse response).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `in_data` this cycle |
| in_data | input | W | Two's-complement input sample |
| dec_factor | input | RW | Decimation factor R |
| rot_shift | input | RW | Zero-rotation parameter r, 0 < r < R |
| out_valid | output | 1 | One-cycle strobe for a new decimated result |
| out_data | output | W+N·RW+1 | Decimated two's-complement result |

## Verification
A capture register loaded at the wrong phase changes the length of the long comb. The impulse response then shows a wrong boxcar length in the first few decimated outputs, and the settled DC value is off at the first result after the response has filled. A phase counter that slips puts a strobe on the wrong accepted sample, which shows at the first downsampling instant after the fault. A corrupted integrator or comb register shows as a wrong value within one decimated period. A state update during an idle cycle shifts every later result.

// File: rtl/zrcic_pkg.sv
// Shared helpers for the zero-rotated CIC decimator.
// Assumes RW bits are enough to hold the largest decimation factor in use.
package zrcic_pkg;

    // Internal and output word width: input width plus growth for R^(N-1)*(2R-r).
    function automatic int acc_width(input int w, input int n, input int rw);
        return w + n * rw + 1;
    endfunction

endpackage

// File: rtl/zrcic_phase_ctrl.sv
// Phase control: counts accepted samples modulo R and produces the downsampling
// strobe (phase 0) and the capture strobe (phase r).
// Assumes 2 <= R and 0 < r < R, with both held constant between resets.
module zrcic_phase_ctrl #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [RW-1:0] dec_factor,
    input  logic [RW-1:0] rot_shift,
    output logic          dn_strobe,
    output logic          cap_strobe
);

    logic [RW-1:0] phase;

    // Strobes are decoded from the phase of the sample presented this cycle.
    assign dn_strobe  = in_valid && (phase == '0);
    assign cap_strobe = in_valid && (phase == rot_shift);

    // Phase counter: advances on each accepted sample and wraps at R-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (in_valid) begin
            if (phase >= dec_factor - 1'b1) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Checker state: accepted samples seen since the last downsampling strobe.
    logic [RW:0] since_dn;
    logic        dn_seen;

    // Checker counter, kept apart from the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_dn <= '0;
            dn_seen  <= 1'b0;
        end else if (in_valid) begin
            if (dn_strobe) begin
                since_dn <= '0;
                dn_seen  <= 1'b1;
            end else begin
                since_dn <= since_dn + 1'b1;
            end
        end
    end

    AST_PARAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (dec_factor >= 2 && rot_shift != '0 && rot_shift < dec_factor)); // R6

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_strobe && dn_seen) |-> (int'(since_dn) == int'(dec_factor) - 1)); // R2

    AST_CAPTURE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> (dn_seen && !dn_strobe && int'(since_dn) == int'(rot_shift) - 1)); // R8

endmodule

// File: rtl/zrcic_integ_chain.sv
// Input-rate integrator cascade. The N stages are chained through their next-state
// values, so after accepting sample n the last register holds the N-fold running sum
// up to and including x[n]. Wrap-around two's-complement arithmetic.
// Assumes in_data is sign-extended to ACC_W here.
module zrcic_integ_chain #(
    parameter int W     = 8,
    parameter int N     = 3,
    parameter int ACC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    output logic [ACC_W-1:0] integ_out
);

    logic [ACC_W-1:0] acc_q   [N];
    logic [ACC_W-1:0] acc_nxt [N];
    logic [ACC_W-1:0] x_ext;

    // Sign extension of the incoming sample to the full internal width.
    assign x_ext = {{(ACC_W-W){in_data[W-1]}}, in_data};

    for (genvar k = 0; k < N; k++) begin : g_stage
        // Next value of stage k: its own sum plus the stage feeding it.
        if (k == 0) begin : g_first
            assign acc_nxt[k] = acc_q[k] + x_ext;
        end else begin : g_rest
            assign acc_nxt[k] = acc_q[k] + acc_nxt[k-1];
        end

        // Stage register: updates only on accepted samples.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
            end else if (in_valid) begin
                acc_q[k] <= acc_nxt[k];
            end
        end
    end

    assign integ_out = acc_q[N-1];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(integ_out)); // R5

endmodule

// File: rtl/zrcic_comb_chain.sv
// Low-rate comb section. The first stage is the lengthened comb: a capture register
// loaded by the capture strobe, plus one register enabled at the low rate that delays
// it by one decimated period, so stage 0 subtracts a value 2R-r input samples old.
// N-1 ordinary combs of delay one decimated sample follow. The result and the valid
// strobe are registered on the downsampling strobe.
// Assumes capture and downsampling strobes never coincide.
module zrcic_comb_chain #(
    parameter int N     = 3,
    parameter int ACC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dn_strobe,
    input  logic             cap_strobe,
    input  logic [ACC_W-1:0] integ_in,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data
);

    logic [ACC_W-1:0] cap_q;
    logic [ACC_W-1:0] lag_q;
    logic [ACC_W-1:0] diff [N];

    // Capture register: takes the integrator output r samples after each instant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_strobe) begin
            cap_q <= integ_in;
        end
    end

    // Low-rate delay register: holds the capture from the previous decimated period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag_q <= '0;
        end else if (dn_strobe) begin
            lag_q <= cap_q;
        end
    end

    // Lengthened comb: the current downsampled sample minus the 2R-r old one.
    assign diff[0] = integ_in - lag_q;

    for (genvar k = 1; k < N; k++) begin : g_comb
        logic [ACC_W-1:0] dly_q;

        // Ordinary comb delay register, enabled at the low rate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (dn_strobe) begin
                dly_q <= diff[k-1];
            end
        end

        assign diff[k] = diff[k-1] - dly_q;
    end

    // Output register and its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= dn_strobe;
            if (dn_strobe) begin
                out_data <= diff[N-1];
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_strobe |=> ($stable(out_data) && !out_valid)); // R5

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_strobe && cap_strobe)); // R8

endmodule

// File: rtl/zr_cic_decim.sv
// Zero-rotated CIC decimator top: phase control, input-rate integrators and the
// low-rate comb section with one comb lengthened to 2R-r.
// Assumes dec_factor and rot_shift are legal and are changed only across a reset.
module zr_cic_decim #(
    parameter  int W     = 8,
    parameter  int N     = 3,
    parameter  int RW    = 4,
    localparam int ACC_W = zrcic_pkg::acc_width(W, N, RW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    input  logic [RW-1:0]    dec_factor,
    input  logic [RW-1:0]    rot_shift,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data
);

    logic             dn_strobe;
    logic             cap_strobe;
    logic [ACC_W-1:0] integ_out;

    zrcic_phase_ctrl #(.RW(RW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .dec_factor (dec_factor),
        .rot_shift  (rot_shift),
        .dn_strobe  (dn_strobe),
        .cap_strobe (cap_strobe)
    );

    zrcic_integ_chain #(.W(W), .N(N), .ACC_W(ACC_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .integ_out (integ_out)
    );

    zrcic_comb_chain #(.N(N), .ACC_W(ACC_W)) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .dn_strobe  (dn_strobe),
        .cap_strobe (cap_strobe),
        .integ_in   (integ_out),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // Checker flag: set once the first result after reset has been presented.
    logic first_done;

    // Tracks whether a result has been presented since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_done <= 1'b0;
        end else if (out_valid) begin
            first_done <= 1'b1;
        end
    end

    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !first_done) |-> (out_data == '0)); // R1

endmodule

// File: tb/sim_zr_cic_decim.sv
module sim_zr_cic_decim;

    localparam int W     = 8;
    localparam int N     = 3;
    localparam int RW    = 4;
    localparam int ACC_W = W + N * RW + 1;
    localparam int NCASE = 8;

    // Each row: R, r, pattern (0 impulse, 1 +max, 2 -max, 3 pseudo-random, 4 alternating), gaps
    localparam int CASES [NCASE][4] = '{
        '{5,  3, 0, 0},
        '{8,  5, 1, 0},
        '{8,  5, 2, 0},
        '{15, 1, 3, 0},
        '{15, 14, 2, 0},
        '{2,  1, 3, 1},
        '{5,  3, 3, 1},
        '{4,  2, 4, 0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [W-1:0]     in_data = '0;
    logic [RW-1:0]    dec_factor = 4'd5;
    logic [RW-1:0]    rot_shift = 4'd3;
    logic             out_valid;
    logic [ACC_W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    longint xs [256];
    longint hh [64];
    int     hlen;

    zr_cic_decim #(.W(W), .N(N), .RW(RW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .dec_factor (dec_factor),
        .rot_shift  (rot_shift),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint out_s();
        return longint'($signed(out_data));
    endfunction

    // Impulse response from the requirement: boxcar(2R-r) convolved with N-1 boxcar(R).
    task automatic build_h(input int rr, input int rot);
        longint tmp [64];
        hlen = 2 * rr - rot;
        for (int i = 0; i < 64; i++) hh[i] = (i < hlen) ? 1 : 0;
        for (int s = 1; s < N; s++) begin
            for (int j = 0; j < 64; j++) begin
                tmp[j] = 0;
                for (int t = 0; t < rr; t++) if (j - t >= 0) tmp[j] += hh[j - t];
            end
            hlen = hlen + rr - 1;
            for (int j = 0; j < 64; j++) hh[j] = tmp[j];
        end
    endtask

    function automatic longint model(input int idx);
        longint acc = 0;
        for (int k = 0; k < hlen; k++) if (idx - k >= 0) acc += hh[k] * xs[idx - k];
        return acc;
    endfunction

    function automatic longint pattern(input int pat, input int n);
        case (pat)
            0: return (n == 0) ? 1 : 0;
            1: return 127;
            2: return -128;
            3: return longint'(((n * 73 + 29) % 256) - 128);
            default: return (n % 2 == 0) ? 100 : -100;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One idle cycle: nothing may move (R5).
    task automatic idle_step();
        longint prev;
        prev = out_s();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R5 idle valid", longint'(out_valid), 0);
        check("R5 idle data", out_s(), prev);
    endtask

    // Accept sample n and check the strobe and value (R2, R3).
    task automatic sample_step(input int n, input longint x, input int rr, input string tag);
        xs[n] = x;
        in_valid = 1'b1;
        in_data = W'(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (n % rr == 0) begin
            check("R2 strobe at instant", longint'(out_valid), 1);
            check(tag, out_s(), model(n - 1));
        end else begin
            check("R2 no strobe", longint'(out_valid), 0);
        end
    endtask

    initial begin
        // R1: reset state at the ports
        do_reset();
        check("R1 reset valid", longint'(out_valid), 0);
        check("R1 reset data", out_s(), 0);

        for (int c = 0; c < NCASE; c++) begin
            int rr  = CASES[c][0];
            int rot = CASES[c][1];
            int pat = CASES[c][2];
            int gap = CASES[c][3];
            int ns  = 12 * rr;
            string tag;
            tag = (pat == 0) ? "R8 impulse" : "R3/R6 value";
            dec_factor = RW'(rr);
            rot_shift  = RW'(rot);
            build_h(rr, rot);
            do_reset();
            for (int n = 0; n < ns; n++) begin
                if (gap != 0 && n % 3 == 1) idle_step();
                sample_step(n, pattern(pat, n), rr, tag);
            end
            // Settled DC gain for constant patterns (R4, R7)
            if (pat == 1) check("R4 dc gain", out_s(), 127 * longint'(rr) * rr * (2 * rr - rot));
            if (pat == 2) check("R7 negative full scale", out_s(),
                                -128 * longint'(rr) * rr * (2 * rr - rot));
        end

        // Directed: reset in mid-stream clears every stage (R1)
        dec_factor = 4'd6;
        rot_shift  = 4'd2;
        build_h(6, 2);
        do_reset();
        for (int n = 0; n < 20; n++) sample_step(n, 90, 6, "R3 pre-reset");
        do_reset();
        check("R1 mid reset valid", longint'(out_valid), 0);
        check("R1 mid reset data", out_s(), 0);
        for (int i = 0; i < 256; i++) xs[i] = 0;
        sample_step(0, 50, 6, "R1 first result zero");
        check("R1 first result", out_s(), 0);
        for (int n = 1; n < 13; n++) sample_step(n, -77, 6, "R3 post-reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule